// File: doc/BRIEF.md
# Single-Digit Calculator Entry Sequencer

This block receives key codes that have already been debounced and steps through one calculation in a fixed order. The order is a first digit, then an operator, then a second digit, then an equals key. It forms the sum, difference or product of the two decimal digits. An 8-bit binary value goes out for display: it shows the digit just entered, and after equals it shows the result. A later stage converts that value to decimal digits and drives the display.

Each accepted key moves the sequence one step, and keys are taken only on a key-valid pulse. A key that does not fit the current step is dropped. A dropped key leaves the step and the display unchanged. The start input is active-high. While it is asserted, the sequencer is held at the first-operand step.

Top module: `calc_seq`

## Requirements
- R1: After reset `disp_o` is 0 and the sequencer waits for a first operand.
- R2: While `start_i` is high the sequencer stays at the first-operand step, and key pulses have no effect on `disp_o` or on the stored operands.
- R3: At the first-operand step a key-valid pulse with a digit code (0 to 9, code equals digit value) stores that digit. The digit appears on `disp_o` after the clock edge, and the sequencer moves to the operator step.
- R4: At the operator step, code 10 selects add, code 11 selects subtract and code 12 selects multiply. The sequencer then moves to the second-operand step, and `disp_o` keeps showing the first operand.
- R5: At the second-operand step a digit code stores the second operand. That digit appears on `disp_o`, and the sequencer moves to the equals step.
- R6: At the equals step only code 13 is accepted. It places the result of the selected operation on `disp_o` and moves to the result step.
- R7: Add and multiply results are exact unsigned values, the largest being 81 (9 times 9).
- R8: A subtraction whose second digit is larger appears as its 8-bit two's-complement value (3 minus 7 gives 252).
- R9: A code that is not valid for the current step (including 14, 15 and 31) is ignored. The step does not change and `disp_o` is unchanged.
- R10: At the result step any key-valid pulse returns the sequencer to the first-operand step. That key is not stored, and `disp_o` keeps the result.
- R11: Without a key-valid pulse neither the step nor `disp_o` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Holds the sequencer at the first-operand step while high |
| key_vld_i | input | 1 | One-cycle pulse marking a new key code |
| key_code_i | input | 5 | Key code: 0-9 digits, 10 add, 11 subtract, 12 multiply, 13 equals |
| disp_o | output | 8 | Binary value to display |

## Verification
A step register that is wrong shows up on the next accepted key. The digit, operator or equals key then either fails to move `disp_o` when it should, or moves it when it should not. This is visible at the sample point one edge after that key. A wrong stored operand or operator only shows at the equals key, so every operator is run with several operand pairs, including the largest product and a negative difference. Runs that inject invalid codes and start pulses confirm that the sequence continues from the expected step.

// File: rtl/calc_pkg.sv
package calc_pkg;
  localparam int KEY_W  = 5;
  localparam int DIG_W  = 4;
  localparam int DATA_W = 8;

  localparam int K_DIG_MAX = 9;
  localparam int K_ADD     = 10;
  localparam int K_SUB     = 11;
  localparam int K_MUL     = 12;
  localparam int K_EQ      = 13;

  // step encoding follows the entry order
  typedef enum logic [2:0] {
    ST_A   = 3'b000,
    ST_OP  = 3'b001,
    ST_B   = 3'b010,
    ST_EQ  = 3'b011,
    ST_RES = 3'b100
  } step_e;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2
  } op_e;
endpackage

// File: rtl/calc_key_class.sv
module calc_key_class
  import calc_pkg::*;
#(
  parameter int KW = KEY_W
) (
  input  logic [KW-1:0] code_i,
  output logic          is_digit_o,
  output logic          is_op_o,
  output logic          is_eq_o,
  output op_e           op_o
);
  always_comb begin
    is_digit_o = (int'(code_i) <= K_DIG_MAX);
    is_op_o    = (int'(code_i) >= K_ADD) && (int'(code_i) <= K_MUL);
    is_eq_o    = (int'(code_i) == K_EQ);
    if (int'(code_i) == K_SUB)      op_o = OP_SUB;
    else if (int'(code_i) == K_MUL) op_o = OP_MUL;
    else                            op_o = OP_ADD;
  end
endmodule

// File: rtl/calc_step_ctrl.sv
module calc_step_ctrl
  import calc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  logic  key_vld_i,
  input  logic  is_digit_i,
  input  logic  is_op_i,
  input  logic  is_eq_i,
  output step_e step_o,
  output logic  acc_o
);
  step_e step_q, step_d;

  always_comb begin
    step_d = step_q;
    if (key_vld_i) begin
      case (step_q)
        ST_A:    if (is_digit_i) step_d = ST_OP;
        ST_OP:   if (is_op_i)    step_d = ST_B;
        ST_B:    if (is_digit_i) step_d = ST_EQ;
        ST_EQ:   if (is_eq_i)    step_d = ST_RES;
        ST_RES:  step_d = ST_A;
        default: step_d = ST_A;
      endcase
    end
  end

  assign acc_o  = key_vld_i && !start_i && (step_d != step_q);
  assign step_o = step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      step_q <= ST_A;
    else if (start_i) step_q <= ST_A;
    else              step_q <= step_d;
  end

  // R2
  start_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> step_q == ST_A);

  // R1
  step_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q <= ST_RES);

  // R6
  eq_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q == ST_EQ && key_vld_i && !is_eq_i && !start_i) |=> step_q == ST_EQ);

  // R10
  res_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q == ST_RES && key_vld_i && !start_i) |=> step_q == ST_A);

  // R11
  idle_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!key_vld_i && !start_i) |=> $stable(step_q));
endmodule

// File: rtl/calc_alu.sv
module calc_alu
  import calc_pkg::*;
#(
  parameter int DW = DIG_W,
  parameter int RW = DATA_W
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  op_e           op_i,
  output logic [RW-1:0] res_o
);
  localparam int PAD = RW - DW;
  logic [RW-1:0] a_x, b_x;

  assign a_x = {{PAD{1'b0}}, a_i};
  assign b_x = {{PAD{1'b0}}, b_i};

  always_comb begin
    case (op_i)
      OP_SUB:  res_o = a_x - b_x;
      OP_MUL:  res_o = a_x * b_x;
      default: res_o = a_x + b_x;
    endcase
  end
endmodule

// File: rtl/calc_seq.sv
module calc_seq
  import calc_pkg::*;
#(
  parameter int KW = KEY_W,
  parameter int DW = DIG_W,
  parameter int RW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          key_vld_i,
  input  logic [KW-1:0] key_code_i,
  output logic [RW-1:0] disp_o
);
  localparam int PAD = RW - DW;

  logic          is_digit, is_op, is_eq, acc;
  op_e           key_op, op_q;
  step_e         step;
  logic [DW-1:0] opa_q, opb_q, digit;
  logic [RW-1:0] alu_res, disp_q;

  assign digit = key_code_i[DW-1:0];

  calc_key_class #(.KW(KW)) u_class (
    .code_i     (key_code_i),
    .is_digit_o (is_digit),
    .is_op_o    (is_op),
    .is_eq_o    (is_eq),
    .op_o       (key_op)
  );

  calc_step_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .key_vld_i  (key_vld_i),
    .is_digit_i (is_digit),
    .is_op_i    (is_op),
    .is_eq_i    (is_eq),
    .step_o     (step),
    .acc_o      (acc)
  );

  calc_alu #(.DW(DW), .RW(RW)) u_alu (
    .a_i   (opa_q),
    .b_i   (opb_q),
    .op_i  (op_q),
    .res_o (alu_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opa_q  <= '0;
      opb_q  <= '0;
      op_q   <= OP_ADD;
      disp_q <= '0;
    end else if (acc) begin
      case (step)
        ST_A: begin
          opa_q  <= digit;
          disp_q <= {{PAD{1'b0}}, digit};
        end
        ST_OP: op_q <= key_op;
        ST_B: begin
          opb_q  <= digit;
          disp_q <= {{PAD{1'b0}}, digit};
        end
        ST_EQ:   disp_q <= alu_res;
        default: ;
      endcase
    end
  end

  assign disp_o = disp_q;

  // R11
  disp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !key_vld_i |=> $stable(disp_o));

  // R2
  start_disp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> $stable(disp_o));

  // R4
  op_disp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step == ST_OP) |=> $stable(disp_o));

  // R7
  res_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step == ST_EQ && acc && op_q != OP_SUB) |=> disp_o <= RW'(81));
endmodule

// File: tb/sim_calc_seq.sv
module sim_calc_seq;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic       key_vld_i = 1'b0;
  logic [4:0] key_code_i = 5'd31;
  logic [7:0] disp_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  // reference model state
  int         m_step = 0;
  logic [7:0] ma = 0, mb = 0, md = 0;
  int         mop = 0;

  calc_seq u0 (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .key_vld_i  (key_vld_i),
    .key_code_i (key_code_i),
    .disp_o     (disp_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic push(string tag);
    exp_q.push_back(md);
    tag_q.push_back(tag);
  endtask

  task automatic model(int c);
    if (start_i) begin
      m_step = 0;
      return;
    end
    case (m_step)
      0: if (c <= 9) begin ma = 8'(c); md = 8'(c); m_step = 1; end
      1: if (c >= 10 && c <= 12) begin mop = c; m_step = 2; end
      2: if (c <= 9) begin mb = 8'(c); md = 8'(c); m_step = 3; end
      3: if (c == 13) begin
           if (mop == 10)      md = ma + mb;
           else if (mop == 11) md = ma - mb;
           else                md = ma * mb;
           m_step = 4;
         end
      default: m_step = 0;
    endcase
  endtask

  task automatic press(int c, string tag);
    @(negedge clk_i);
    key_vld_i  = 1'b1;
    key_code_i = 5'(c);
    model(c);
    @(negedge clk_i);
    key_vld_i  = 1'b0;
    key_code_i = 5'd31;
    push(tag);
  endtask

  task automatic calc(int a, int o, int b, string tag);
    press(a, tag);
    press(o, tag);
    press(b, tag);
    press(13, tag);
    press(0, "R10");
  endtask

  // monitor
  initial forever begin
    @(negedge clk_i);
    #1;
    while (exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (disp_o !== e) begin
        n_bad++;
        $display("FAIL %s: disp_o=%0d expected=%0d", t, disp_o, e);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    push("R1");
    @(negedge clk_i);

    calc(1, 10, 2, "R7");      // 3
    calc(5, 12, 6, "R7");      // 30
    calc(9, 12, 9, "R7");      // 81
    calc(7, 11, 2, "R4");      // 5
    calc(3, 11, 7, "R8");      // 252
    calc(0, 11, 9, "R8");      // 247

    // invalid codes at each step
    press(10, "R9"); press(14, "R9");
    press(4, "R3");
    press(3, "R9"); press(13, "R9");
    press(11, "R4");
    press(12, "R9"); press(15, "R9");
    press(8, "R5");
    press(2, "R9"); press(31, "R9"); press(10, "R9");
    press(13, "R6");           // 4-8 = 252
    press(5, "R10");
    press(6, "R3");

    // start held mid sequence
    @(negedge clk_i); start_i = 1'b1;
    press(9, "R2");
    press(10, "R2");
    @(negedge clk_i); start_i = 1'b0; m_step = 0;
    press(2, "R2");
    press(10, "R4");
    press(7, "R5");
    repeat (10) @(negedge clk_i);
    push("R11");
    press(13, "R6");           // 9
    repeat (5) @(negedge clk_i);
    push("R11");

    repeat (3) @(negedge clk_i);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule